// File: doc/BRIEF.md
# Blink-Phase Port and Interrupt-Pin Controller

This block is the output-control core of an eight-port open-drain I/O expander. A host reaches it over a small parallel register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. The block holds a control register and two port-pattern registers. Each port is modelled as a drive-low enable. A pattern bit of 0 pulls its port low, and a pattern bit of 1 lets the port float.

When blinking is off, pattern A alone sets the ports. When blinking is on, the active phase picks pattern A or pattern B. The active phase is a software flip bit XORed with an external blink input, and that input first passes through a two-flop synchroniser. If pattern B is all ones, the blink input acts as a hardware gate on the ports. A pulse-width waveform on the blink input then fades the port drive.

A shared open-drain pin has two uses. It can serve as a general-purpose output whose level tracks the blink phase. It can also serve as a change interrupt that asserts when the synchronised port inputs differ from a snapshot taken at the last read of the input register. Reading the input register clears the interrupt and reloads the snapshot.

Top module: `blinkport_ctrl`

Register map: input register at 0x0, pattern A at 0x2, pattern B at 0xA, control register at 0xF. Control bits: bit 0 blink enable (E), bit 1 flip (F), bit 2 intensity flag (stored only), bit 3 interrupt mode (I), bit 4 level for phase 0 (L0), bit 5 level for phase 1 (L1), bit 6 reads 0, bit 7 reads the change status.

## Requirements
- R1: After reset, both pattern registers read 0xFF. The control register reads 0x0C. No port and not the shared pin is driven low.
- R2: With E=0, the port drive-low vector equals the inverse of pattern A, whatever F and the blink input are.
- R3: With E=1, the phase is F XOR the blink input as seen after two clock edges. Phase 0 selects pattern A and phase 1 selects pattern B.
- R4: A pattern bit of 1 leaves its port floating, and a bit of 0 drives that port low.
- R5: With I=0 and E=0, the shared pin is driven low exactly when L0 is 0.
- R6: With I=0 and E=1, the shared pin follows L0 in phase 0 and L1 in phase 1. A level of 0 drives the pin low.
- R7: With I=1, the shared pin is driven low exactly while a change is pending. Control bit 7 reads the pending flag.
- R8: A read strobe at address 0x0 returns the synchronised inputs, clears the pending flag and reloads the snapshot. Inputs that settle through the synchroniser in the same cycle as that read raise the flag again on the next edge.
- R9: Writes to control bits 7 and 6 have no effect, and bit 6 always reads 0.
- R10: With pattern B at 0xFF and E=1, each cycle of the blink input floats all ports two edges later, and each low cycle restores pattern A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; side effects only at address 0x0 |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| blink_in | input | 1 | Asynchronous hardware blink input |
| port_in | input | 8 | Asynchronous port input levels |
| port_drive_low | output | 8 | 1 = pull port low, 0 = float |
| irq_drive_low | output | 1 | 1 = pull shared pin low, 0 = float |

## Verification
The read that clears the pending flag and the arrival of new port data at the end of the synchroniser can fall on the same clock edge. The bench provokes this by changing port_in one edge before it strobes a read of the input register. The read returns the old synchronised value. The bench then expects the shared pin to go low on the following edge, because the new data must not be lost. A second, later read with quiet inputs must leave the pin floating.

// File: rtl/blinkport_pkg.sv
package blinkport_pkg;
  localparam int REG_W = 8;
  localparam int ADR_W = 4;

  localparam logic [ADR_W-1:0] ADR_INPUT = 4'h0;
  localparam logic [ADR_W-1:0] ADR_PAT_A = 4'h2;
  localparam logic [ADR_W-1:0] ADR_PAT_B = 4'hA;
  localparam logic [ADR_W-1:0] ADR_CTRL  = 4'hF;

  localparam int CB_EN    = 0;
  localparam int CB_FLIP  = 1;
  localparam int CB_GINT  = 2;
  localparam int CB_IRQ   = 3;
  localparam int CB_LVL0  = 4;
  localparam int CB_LVL1  = 5;
  localparam int CTRL_STORED = 6;

  localparam logic [CTRL_STORED-1:0] CTRL_RESET = 6'h0C;

  // Pattern bit 1 floats the port; the drive-low vector is its inverse.
  function automatic logic [REG_W-1:0] port_low_vec(
      input logic en, input logic phase,
      input logic [REG_W-1:0] pat_a, input logic [REG_W-1:0] pat_b);
    port_low_vec = ~((en && phase) ? pat_b : pat_a);
  endfunction

  function automatic logic shared_pin_low(
      input logic irq_mode, input logic en, input logic phase,
      input logic lvl0, input logic lvl1, input logic pending);
    if (irq_mode) shared_pin_low = pending;
    else          shared_pin_low = !((en && phase) ? lvl1 : lvl0);
  endfunction
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] first,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  generate
    for (genvar k = 1; k < N; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
      end
    end
  endgenerate

  assign first = stg[0];
  assign q     = stg[N-1];
endmodule

// File: rtl/bp_chg_detect.sv
module bp_chg_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic         clr,
  output logic [W-1:0] snap_q,
  output logic         pend_q
);
  logic differ;
  assign differ = (pin_s != snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      snap_q <= pin_s;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_q | differ;
    end
  end
endmodule

// File: rtl/bp_out_mux.sv
module bp_out_mux
  import blinkport_pkg::*;
(
  input  logic             en,
  input  logic             irq_mode,
  input  logic             lvl0,
  input  logic             lvl1,
  input  logic             phase,
  input  logic             pending,
  input  logic [REG_W-1:0] pat_a,
  input  logic [REG_W-1:0] pat_b,
  output logic [REG_W-1:0] port_drive_low,
  output logic             irq_drive_low
);
  assign port_drive_low = port_low_vec(en, phase, pat_a, pat_b);
  assign irq_drive_low  = shared_pin_low(irq_mode, en, phase, lvl0, lvl1, pending);
endmodule

// File: rtl/blinkport_ctrl.sv
module blinkport_ctrl
  import blinkport_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             blink_in,
  input  logic [REG_W-1:0] port_in,
  output logic [REG_W-1:0] port_drive_low,
  output logic             irq_drive_low
);
  logic [REG_W-1:0]       ph0_q, ph1_q;
  logic [CTRL_STORED-1:0] ctrl_q;
  logic                   cfg_e, cfg_f, cfg_i, cfg_o0, cfg_o1;
  logic                   blink_m, blink_s, phase;
  logic [REG_W-1:0]       pin_m, pin_s, snap_q;
  logic                   chg_q, rd_in_hit;

  assign cfg_e  = ctrl_q[CB_EN];
  assign cfg_f  = ctrl_q[CB_FLIP];
  assign cfg_i  = ctrl_q[CB_IRQ];
  assign cfg_o0 = ctrl_q[CB_LVL0];
  assign cfg_o1 = ctrl_q[CB_LVL1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph0_q  <= '1;
      ph1_q  <= '1;
      ctrl_q <= CTRL_RESET;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_PAT_A: ph0_q  <= bus_wdata;
        ADR_PAT_B: ph1_q  <= bus_wdata;
        ADR_CTRL:  ctrl_q <= bus_wdata[CTRL_STORED-1:0];
        default: ;
      endcase
    end
  end

  bp_sync #(.W(1), .N(SYNC_N)) u_blink_sync (
    .clk(clk), .rst_n(rst_n), .d(blink_in), .first(blink_m), .q(blink_s));

  bp_sync #(.W(REG_W), .N(SYNC_N)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .first(pin_m), .q(pin_s));

  assign phase     = cfg_f ^ blink_s;
  assign rd_in_hit = bus_rd && (bus_addr == ADR_INPUT);

  bp_chg_detect #(.W(REG_W)) u_chg (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .clr(rd_in_hit),
    .snap_q(snap_q), .pend_q(chg_q));

  bp_out_mux u_mux (
    .en(cfg_e), .irq_mode(cfg_i), .lvl0(cfg_o0), .lvl1(cfg_o1),
    .phase(phase), .pending(chg_q), .pat_a(ph0_q), .pat_b(ph1_q),
    .port_drive_low(port_drive_low), .irq_drive_low(irq_drive_low));

  always_comb begin
    case (bus_addr)
      ADR_INPUT: bus_rdata = pin_s;
      ADR_PAT_A: bus_rdata = ph0_q;
      ADR_PAT_B: bus_rdata = ph1_q;
      ADR_CTRL:  bus_rdata = {chg_q, 1'b0, ctrl_q};
      default:   bus_rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^pin_m;
endmodule

// File: rtl/blinkport_ctrl_chk.sv
module blinkport_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_e,
  input logic       cfg_i,
  input logic       cfg_o1,
  input logic       phase,
  input logic [7:0] ph0_q,
  input logic [7:0] ph1_q,
  input logic [7:0] port_drive_low,
  input logic       irq_drive_low,
  input logic       chg_q,
  input logic [7:0] snap_q,
  input logic [7:0] pin_s,
  input logic       blink_m,
  input logic       blink_s,
  input logic       rd_in_hit
);
  a_r3_sync_stage: assert property (@(posedge clk) disable iff (!rst_n)
    blink_s == $past(blink_m));

  a_r4_all_float: assert property (@(posedge clk) disable iff (!rst_n)
    (ph0_q == 8'hFF && ph1_q == 8'hFF) |-> port_drive_low == 8'h00);

  a_r2_pattern_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_e && $stable(ph0_q) && $stable(cfg_e)) |-> $stable(port_drive_low));

  a_r6_level1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i && cfg_e && phase) |-> irq_drive_low == !cfg_o1);

  a_r7_pin_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i |-> irq_drive_low == chg_q);

  a_r8_snap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in_hit |=> (snap_q == $past(pin_s)));
endmodule

bind blinkport_ctrl blinkport_ctrl_chk chk_i (.*);

// File: tb/blinkport_ctrl_tb_top.sv
module blinkport_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       blink_in = 1'b0;
  logic [7:0] port_in = '0;
  logic [7:0] port_drive_low;
  logic       irq_drive_low;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blinkport_ctrl dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, input bit strobe);
    @(negedge clk);
    bus_addr = a; bus_rd = strobe;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ports", port_drive_low, 8'h00);
    check("R1 pin", {7'd0, irq_drive_low}, 8'h00);
    rd(4'h2, v, 0); check("R1 patA", v, 8'hFF);
    rd(4'hA, v, 0); check("R1 patB", v, 8'hFF);
    rd(4'hF, v, 0); check("R1 ctrl", v, 8'h0C);
  endtask

  task automatic t_ctrl_ignore();
    logic [7:0] v;
    wr(4'hF, 8'hCC);
    rd(4'hF, v, 0); check("R9 bits7/6", v, 8'h0C);
  endtask

  task automatic t_patterns();
    wr(4'h2, 8'h0F); wr(4'hA, 8'hF0);
    wr(4'hF, 8'h02);                       // E=0, F=1, I=0, L0=0
    blink_in = 1'b1; repeat (3) @(negedge clk);
    check("R2 patA only", port_drive_low, 8'hF0);
    check("R4 polarity", port_drive_low & 8'h0F, 8'h00);
    check("R5 L0=0", {7'd0, irq_drive_low}, 8'h01);
    wr(4'hF, 8'h12);                       // L0=1
    check("R5 L0=1", {7'd0, irq_drive_low}, 8'h00);
    blink_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic t_blink();
    wr(4'hF, 8'h21);                       // E=1, F=0, L1=1, L0=0
    check("R3 phase0", port_drive_low, 8'hF0);
    check("R6 phase0 L0", {7'd0, irq_drive_low}, 8'h01);
    wr(4'hF, 8'h23);                       // F=1
    check("R3 flip", port_drive_low, 8'h0F);
    check("R6 phase1 L1", {7'd0, irq_drive_low}, 8'h00);
    @(negedge clk); blink_in = 1'b1;
    @(negedge clk);
    check("R3 one edge", port_drive_low, 8'h0F);
    @(negedge clk);
    check("R3 two edges", port_drive_low, 8'hF0);
    blink_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic t_pwm_gate();
    logic [7:0] pat = 8'b10110010;
    wr(4'h2, 8'h00); wr(4'hA, 8'hFF); wr(4'hF, 8'h01);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] e;
      if (i < 2) e = 8'hFF;
      else       e = pat[i-2] ? 8'h00 : 8'hFF;
      check("R10 gate", port_drive_low, e);
      if (i < 8) blink_in = pat[i];
      else       blink_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_change();
    logic [7:0] v;
    wr(4'hF, 8'h08);                       // I=1
    check("R7 idle", {7'd0, irq_drive_low}, 8'h00);
    port_in = 8'h3C; repeat (3) @(negedge clk);
    check("R7 pending pin", {7'd0, irq_drive_low}, 8'h01);
    rd(4'hF, v, 0); check("R7 status bit", v, 8'h88);
    rd(4'h0, v, 1); check("R8 read value", v, 8'h3C);
    check("R8 cleared", {7'd0, irq_drive_low}, 8'h00);
    // Same-cycle collision: new data reaches the synchroniser output
    // on the very edge that carries the clearing read.
    @(negedge clk); port_in = 8'h55;
    @(negedge clk);
    bus_addr = 4'h0; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
    check("R8 collision old data", v, 8'h3C);
    @(negedge clk);
    check("R8 collision kept", {7'd0, irq_drive_low}, 8'h01);
    rd(4'h0, v, 1); check("R8 second read", v, 8'h55);
    @(negedge clk);
    check("R8 quiet", {7'd0, irq_drive_low}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_ignore();
    t_patterns();
    t_blink();
    t_pwm_gate();
    t_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule